// File: doc/BRIEF.md
# Programmable-Format Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. Its clock runs at sixteen times the bit rate, and every clock cycle is one sampling tick. A falling edge on the idle line starts a frame. The line is checked again half a bit later, so that a short glitch is not taken for a start bit. After that, each bit is read once near its middle.

The frame format comes from a small control word. A strobe latches the word, and the word then holds until the next strobe. The word gives the character length, whether a parity bit is present and, if it is, whether the parity is even or odd.

When a character completes, the block places it right-justified on a parallel output. It raises a ready flag and updates three error flags together: parity, framing and overrun. A host pulses a clear strobe once it has taken the character. A character that completes while the previous one has not been cleared sets the overrun flag.

Top module: `async_char_rx`

## Requirements
- R1: The length field `cfg_len` selects the number of data bits: 00 selects 5, 01 selects 6, 10 selects 7 and 11 selects 8. The character is right-justified on `rx_data`, and bits above the character length read 0.
- R2: Data bits are taken least significant bit first. They follow one start bit (low) and come before the optional parity bit and the stop bit (high).
- R3: When `cfg_par_off` is 1, no parity bit is expected, `cfg_par_even` has no effect and `err_parity` is 0 for that character.
- R4: When parity is enabled, `cfg_par_even` = 1 selects even parity and 0 selects odd parity. The parity sense is judged over the data bits together with the parity bit. A mismatch sets `err_parity` for that character.
- R5: Only the first stop bit is examined. If it reads 0, `err_frame` is set for that character.
- R6: If the line is high again at the middle of the start bit, the frame is dropped. No character is delivered, and `rx_ready` is unchanged.
- R7: `rx_ready` is set in the cycle after a character completes. It is cleared in the cycle after a `rd_clr` pulse. The parity, framing and overrun flags change only when a character completes, and they all change together.
- R8: If a character completes while `rx_ready` is still set, `err_overrun` is set and `rx_data` takes the new character. If `rd_clr` arrives in the same cycle as a completion, the completion wins: `rx_ready` stays set and no overrun is flagged.
- R9: The control inputs take effect only on a `cfg_load` pulse. After reset, `rx_data` and all flags are 0, and the format is 8 data bits with no parity.
- R10: Each bit lasts 16 clock cycles and is sampled once, about 9 cycles after it starts. A disturbance in the early part of a bit does not change the received value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, 16 times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Latches the control inputs |
| cfg_len | input | 2 | Character length select |
| cfg_par_off | input | 1 | 1 = no parity bit |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd |
| rx_line | input | 1 | Serial input, idle high |
| rd_clr | input | 1 | Clears the ready flag |
| rx_data | output | 8 | Last received character, right-justified |
| rx_ready | output | 1 | A character is waiting |
| err_parity | output | 1 | Parity mismatch on the last character |
| err_frame | output | 1 | First stop bit of the last character was low |
| err_overrun | output | 1 | The last character arrived before the previous one was cleared |

## Verification
A character completing and the host's clear strobe can fall in the same clock cycle. This is the most delicate interaction in the status logic. The bench first leaves one character uncleared. It then sends a second frame and pulses `rd_clr` exactly on the cycle where the stop bit is sampled. That cycle is 25 + 16·(data bits + parity bits) cycles after the start bit is first driven. The correct outcome is that `rx_ready` stays set, `err_overrun` stays clear and `rx_data` holds the new character. A missing-overrun case and a genuine-overrun case are run on either side of it for contrast.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

    localparam int unsigned DW   = 8;
    localparam int unsigned IDXW = $clog2(DW);

    typedef struct packed {
        logic [1:0] len_sel;
        logic       par_off;
        logic       par_even;
    } rx_cfg_t;

    localparam rx_cfg_t CFG_RESET = '{len_sel: 2'b11, par_off: 1'b1, par_even: 1'b0};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic par_err;
        logic frm_err;
        logic ovr_err;
    } rx_flags_t;

    // number of data bits for a length code
    function automatic logic [3:0] char_len(input logic [1:0] sel);
        return 4'd5 + {2'b00, sel};
    endfunction

    // right-justify a character that was shifted in from the top
    function automatic logic [DW-1:0] align_char(input logic [DW-1:0] sh, input logic [3:0] n);
        return sh >> (4'(DW) - n);
    endfunction

    // 1 when the ones count of data plus parity bit breaks the selected sense
    function automatic logic parity_bad(input logic acc, input logic pbit, input logic even);
        return acc ^ pbit ^ ~even;
    endfunction

endpackage

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import async_rx_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line,
    input  rx_cfg_t       cfg,
    output logic          done,
    output logic [DW-1:0] char_o,
    output logic          par_bad,
    output logic          stop_bad
);
    localparam int unsigned CW = $clog2(OSR);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    rx_state_e      st;
    logic [CW-1:0]  tick;
    logic [IDXW-1:0] idx;
    logic [DW-1:0]  shreg;
    logic           acc;
    logic           perr_q;
    logic           sample;
    logic [3:0]     nbits;

    assign sample = (tick == LAST);
    assign nbits  = char_len(cfg.len_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            tick   <= '0;
            idx    <= '0;
            shreg  <= '0;
            acc    <= 1'b0;
            perr_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (!line) begin
                        st     <= ST_START;
                        tick   <= '0;
                        idx    <= '0;
                        acc    <= 1'b0;
                        perr_q <= 1'b0;
                    end
                end
                ST_START: begin
                    if (tick == MID) begin
                        tick <= '0;
                        st   <= line ? ST_IDLE : ST_DATA;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                ST_DATA: begin
                    tick <= sample ? '0 : tick + 1'b1;
                    if (sample) begin
                        shreg <= {line, shreg[DW-1:1]};
                        acc   <= acc ^ line;
                        if ({1'b0, idx} == nbits - 4'd1)
                            st <= cfg.par_off ? ST_STOP : ST_PAR;
                        else
                            idx <= idx + 1'b1;
                    end
                end
                ST_PAR: begin
                    tick <= sample ? '0 : tick + 1'b1;
                    if (sample) begin
                        perr_q <= parity_bad(acc, line, cfg.par_even);
                        st     <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    tick <= sample ? '0 : tick + 1'b1;
                    if (sample) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign done     = (st == ST_STOP) && sample;
    assign stop_bad = ~line;
    assign par_bad  = perr_q;
    assign char_o   = align_char(shreg, nbits);

    // R7: a completion is a single-cycle event
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/rx_status.sv
module rx_status
    import async_rx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          done,
    input  logic [DW-1:0] char_i,
    input  logic          par_bad,
    input  logic          stop_bad,
    input  logic          clr,
    output logic [DW-1:0] data_o,
    output logic          ready_o,
    output rx_flags_t     flags_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_o  <= '0;
            ready_o <= 1'b0;
            flags_o <= '0;
        end else if (done) begin
            data_o          <= char_i;
            ready_o         <= 1'b1;
            flags_o.par_err <= par_bad;
            flags_o.frm_err <= stop_bad;
            flags_o.ovr_err <= ready_o & ~clr;
        end else if (clr) begin
            ready_o <= 1'b0;
        end
    end

    // R7: completion raises ready
    a_r7_ready_set: assert property (@(posedge clk) disable iff (rst)
        done |=> ready_o);

    // R7: clear without completion drops ready
    a_r7_ready_clr: assert property (@(posedge clk) disable iff (rst)
        (clr && !done) |=> !ready_o);

    // R8: completion on top of pending data flags overrun
    a_r8_overrun: assert property (@(posedge clk) disable iff (rst)
        (done && ready_o && !clr) |=> flags_o.ovr_err);

    // R7: error flags hold between completions
    a_r7_flags_hold: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(flags_o));

endmodule

// File: rtl/async_char_rx.sv
module async_char_rx
    import async_rx_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_load,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_off,
    input  logic       cfg_par_even,
    input  logic       rx_line,
    input  logic       rd_clr,
    output logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       err_parity,
    output logic       err_frame,
    output logic       err_overrun
);
    rx_cfg_t       cfg_q;
    logic          line_q;
    logic          done;
    logic [DW-1:0] char_w;
    logic          par_bad;
    logic          stop_bad;
    rx_flags_t     flags;
    logic [3:0]    nbits_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_RESET;
            line_q <= 1'b1;
        end else begin
            line_q <= rx_line;
            if (cfg_load)
                cfg_q <= '{len_sel: cfg_len, par_off: cfg_par_off, par_even: cfg_par_even};
        end
    end

    assign nbits_w = char_len(cfg_q.len_sel);

    rx_frame_fsm #(.OSR(OSR)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .line     (line_q),
        .cfg      (cfg_q),
        .done     (done),
        .char_o   (char_w),
        .par_bad  (par_bad),
        .stop_bad (stop_bad)
    );

    rx_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .done     (done),
        .char_i   (char_w),
        .par_bad  (par_bad),
        .stop_bad (stop_bad),
        .clr      (rd_clr),
        .data_o   (rx_data),
        .ready_o  (rx_ready),
        .flags_o  (flags)
    );

    assign err_parity  = flags.par_err;
    assign err_frame   = flags.frm_err;
    assign err_overrun = flags.ovr_err;

    // R9: format changes only on a load strobe
    a_r9_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> $stable(cfg_q));

    // R1: bits above the character length read zero after completion
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
        done |=> ((rx_data >> $past(nbits_w)) == 8'h00));

endmodule

// File: tb/async_char_rx_bench.sv
module async_char_rx_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_load = 1'b0;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_par_off = 1'b1;
    logic       cfg_par_even = 1'b0;
    logic       rx_line = 1'b1;
    logic       rd_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, err_parity, err_frame, err_overrun;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    async_char_rx u_async_char_rx (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_len(cfg_len),
        .cfg_par_off(cfg_par_off), .cfg_par_even(cfg_par_even),
        .rx_line(rx_line), .rd_clr(rd_clr), .rx_data(rx_data),
        .rx_ready(rx_ready), .err_parity(err_parity), .err_frame(err_frame),
        .err_overrun(err_overrun)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] lmask(input int n);
        return 8'((16'h1 << n) - 1);
    endfunction

    task automatic load_cfg(input logic [1:0] len, input logic poff, input logic peven);
        cfg_len = len; cfg_par_off = poff; cfg_par_even = peven;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic pulse_clr();
        rd_clr = 1'b1;
        @(negedge clk);
        rd_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] val, input int n, input bit par_on,
                              input bit even, input bit flip, input logic stopv);
        logic p;
        rx_line = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            rx_line = val[i];
            repeat (16) @(negedge clk);
        end
        if (par_on) begin
            p = ^(val & lmask(n));
            if (!even) p = ~p;
            if (flip) p = ~p;
            rx_line = p;
            repeat (16) @(negedge clk);
        end
        rx_line = stopv;
        repeat (16) @(negedge clk);
        rx_line = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R9 reset data", rx_data, 0);
        check("R9 reset ready", rx_ready, 0);
        check("R9 reset flags", {err_parity, err_frame, err_overrun}, 0);
    endtask

    task automatic t_default_format();
        send_frame(8'hA5, 8, 0, 0, 0, 1'b1);
        check("R9 default 8N data", rx_data, 8'hA5);
        check("R7 ready set", rx_ready, 1);
        check("R3 default no parity err", err_parity, 0);
        pulse_clr();
        check("R7 ready cleared", rx_ready, 0);
        check("R7 data held after clear", rx_data, 8'hA5);
    endtask

    task automatic t_lengths();
        for (int l = 0; l < 4; l++) begin
            load_cfg(2'(l), 1'b1, 1'b0);
            send_frame(8'hED, 5 + l, 0, 0, 0, 1'b1);
            check("R1 length right-justified", rx_data, 8'hED & lmask(5 + l));
            pulse_clr();
        end
    endtask

    task automatic t_lsb_first();
        load_cfg(2'b11, 1'b1, 1'b0);
        send_frame(8'h01, 8, 0, 0, 0, 1'b1);
        check("R2 lsb first 01", rx_data, 8'h01);
        pulse_clr();
        send_frame(8'h80, 8, 0, 0, 0, 1'b1);
        check("R2 lsb first 80", rx_data, 8'h80);
        pulse_clr();
    endtask

    task automatic t_parity();
        load_cfg(2'b11, 1'b0, 1'b1);
        send_frame(8'h37, 8, 1, 1, 0, 1'b1);
        check("R4 even good", {err_parity, rx_data}, {1'b0, 8'h37});
        pulse_clr();
        send_frame(8'h37, 8, 1, 1, 1, 1'b1);
        check("R4 even bad", err_parity, 1);
        pulse_clr();
        load_cfg(2'b10, 1'b0, 1'b0);
        send_frame(8'h52, 7, 1, 0, 0, 1'b1);
        check("R4 odd good", {err_parity, rx_data}, {1'b0, 8'h52});
        pulse_clr();
        send_frame(8'h52, 7, 1, 0, 1, 1'b1);
        check("R4 odd bad", err_parity, 1);
        pulse_clr();
    endtask

    task automatic t_par_inhibit();
        load_cfg(2'b11, 1'b1, 1'b0);
        send_frame(8'h3C, 8, 0, 0, 0, 1'b1);
        check("R3 inhibit sense 0", {err_parity, rx_data}, {1'b0, 8'h3C});
        pulse_clr();
        load_cfg(2'b11, 1'b1, 1'b1);
        send_frame(8'h3D, 8, 0, 0, 0, 1'b1);
        check("R3 inhibit sense 1", {err_parity, rx_data}, {1'b0, 8'h3D});
        pulse_clr();
    endtask

    task automatic t_framing();
        send_frame(8'h66, 8, 0, 0, 0, 1'b0);
        check("R5 stop low flags frame", {err_frame, rx_data}, {1'b1, 8'h66});
        pulse_clr();
        send_frame(8'h67, 8, 0, 0, 0, 1'b1);
        check("R5 good stop clears frame", err_frame, 0);
        pulse_clr();
    endtask

    task automatic t_false_start();
        rx_line = 1'b0;
        repeat (4) @(negedge clk);
        rx_line = 1'b1;
        repeat (300) @(negedge clk);
        check("R6 false start no char", {rx_ready, rx_data}, {1'b0, 8'h67});
    endtask

    task automatic t_overrun();
        send_frame(8'h11, 8, 0, 0, 0, 1'b1);
        send_frame(8'h22, 8, 0, 0, 0, 1'b1);
        check("R8 overrun flag", {err_overrun, rx_ready}, 2'b11);
        check("R8 overrun overwrites", rx_data, 8'h22);
        pulse_clr();
        check("R7 overrun holds until completion", err_overrun, 1);
        send_frame(8'h33, 8, 0, 0, 0, 1'b1);
        check("R7 overrun updates on completion", err_overrun, 0);
    endtask

    task automatic t_coincide();
        // ready is set here from the previous task
        fork
            send_frame(8'h44, 8, 0, 0, 0, 1'b1);
            begin
                repeat (25 + 16 * 8) @(negedge clk);
                rd_clr = 1'b1;
                @(negedge clk);
                rd_clr = 1'b0;
            end
        join
        check("R8 coincident clear ready", rx_ready, 1);
        check("R8 coincident clear no overrun", err_overrun, 0);
        check("R8 coincident clear data", rx_data, 8'h44);
        pulse_clr();
    endtask

    task automatic t_cfg_latch();
        load_cfg(2'b11, 1'b1, 1'b0);
        cfg_len = 2'b00; cfg_par_off = 1'b0; cfg_par_even = 1'b1;
        @(negedge clk);
        send_frame(8'hF0, 8, 0, 0, 0, 1'b1);
        check("R9 cfg needs load", {err_parity, rx_data}, {1'b0, 8'hF0});
        pulse_clr();
    endtask

    task automatic t_mid_sample();
        rx_line = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            if (i == 3) begin
                rx_line = 1'b1;
                repeat (6) @(negedge clk);
                rx_line = 1'b0;
                repeat (10) @(negedge clk);
            end else begin
                rx_line = 1'b0;
                repeat (16) @(negedge clk);
            end
        end
        rx_line = 1'b1;
        repeat (36) @(negedge clk);
        check("R10 early glitch ignored", {rx_ready, rx_data}, {1'b1, 8'h00});
        pulse_clr();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_default_format();
        t_lengths();
        t_lsb_first();
        t_parity();
        t_par_inhibit();
        t_framing();
        t_false_start();
        t_overrun();
        t_coincide();
        t_cfg_latch();
        t_mid_sample();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule